// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational adder. It takes two operands and a carry input and returns the sum and the carry out. The word is divided into groups of four bits. Each group builds per-bit generate (`a AND b`) and propagate (`a OR b`) terms. From these, the group finds the carries into its own bits in a single lookahead step. It also reduces its bits to one group propagate and one group generate.

A second lookahead stage takes the group propagate and generate signals together with the carry input. It forms the carry into every group and the final carry out directly, so no carry ripples between groups. The path to the carry out is about five gate levels: one for the per-bit terms, two for the group generate and two for the final carry. A 16-bit ripple chain takes about 32.

The group propagate and generate vectors are also output, so a wider adder can use this block as one stage of a deeper lookahead tree. The group width and group count are parameters. The default is four groups of four bits.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, with WIDTH = GRP_W*NUM_GRP (16 by default).
- R2: `cout` equals bit WIDTH of `a + b + cin`.
- R3: `grp_p[k]` is 1 exactly when every bit position i in group k (bits k*GRP_W to k*GRP_W+GRP_W-1) has `a[i] OR b[i]` equal to 1.
- R4: `grp_g[k]` is 1 exactly when adding group k's slice of `a` to group k's slice of `b`, with no carry in, overflows GRP_W bits.
- R5: `cout` equals the group-level lookahead of the outputs themselves: starting with the carry c = `cin`, step through groups 0 to NUM_GRP-1 and set c = `grp_g[k] OR (grp_p[k] AND c)`. The final c must equal `cout`.
- R6: With a=0x1A33, b=0xE5EB and cin=0, the outputs are grp_p=4'b1110, grp_g=4'b0010 and cout=1.
- R7: With all operand bits set to 1 and a unit carry, the sum is zero, cout is 1, every grp_p bit is 1 and every grp_g bit is 0. This holds for both a=all-ones, b=0, cin=1 and for a=all-ones, b=0, cin=1 as a sum of ones; it also holds for a=all-ones, b=1, cin=0, except that grp_g[0] is then 1.
- R8: A reduced configuration with GRP_W=2 and NUM_GRP=2 satisfies R1 to R4 for every combination of operands and carry in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | GRP_W*NUM_GRP | First operand |
| b | input | GRP_W*NUM_GRP | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | GRP_W*NUM_GRP | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| grp_p | output | NUM_GRP | Group propagate, one bit per group |
| grp_g | output | NUM_GRP | Group generate, one bit per group |

## Verification
A 4-bit configuration (two groups of two bits) is swept over all 512 combinations of its inputs. This covers every kill, propagate and generate pattern, both inside a group and across the group boundary.

The 16-bit default is driven with several kinds of vectors:
- The worked example and all-ones plus one, where a carry must pass through every group by propagation alone.
- Walking single bits against an all-ones operand. These move the point where a carry is generated across every group boundary.
- Random vectors.

Each vector checks the group propagate and generate outputs separately from the sum. An error in the second-level lookahead and an error inside a group therefore show up as different failures.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned DEF_GRP_W   = 4;
    localparam int unsigned DEF_NUM_GRP = 4;

    // propagate / generate pair for one bit or one group
    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    function automatic pg_t bit_pg(input logic x, input logic y);
        pg_t r;
        r.p = x | y;
        r.g = x & y;
        return r;
    endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  cla_pkg::pg_t [N-1:0] pg_in,
    input  logic                 cin,
    output logic [N-1:0]         carry,
    output cla_pkg::pg_t         pg_out
);
    // every carry formed as a flat sum of products, no chaining
    always_comb begin
        logic acc;
        logic prod;
        carry = '0;
        for (int i = 0; i < N; i++) begin
            prod = cin;
            for (int k = 0; k < i; k++) prod = prod & pg_in[k].p;
            acc = prod;
            for (int j = 0; j < i; j++) begin
                prod = pg_in[j].g;
                for (int k = j + 1; k < i; k++) prod = prod & pg_in[k].p;
                acc = acc | prod;
            end
            carry[i] = acc;
        end
    end

    always_comb begin
        logic acc;
        logic prod;
        pg_out.p = 1'b1;
        for (int k = 0; k < N; k++) pg_out.p = pg_out.p & pg_in[k].p;
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            prod = pg_in[j].g;
            for (int k = j + 1; k < N; k++) prod = prod & pg_in[k].p;
            acc = acc | prod;
        end
        pg_out.g = acc;
    end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int unsigned GRP_W = 4
) (
    input  logic [GRP_W-1:0] a,
    input  logic [GRP_W-1:0] b,
    input  logic             cin,
    output logic [GRP_W-1:0] sum,
    output cla_pkg::pg_t     grp
);
    cla_pkg::pg_t [GRP_W-1:0] bpg;
    logic [GRP_W-1:0]         c_bit;

    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
        assign bpg[i] = cla_pkg::bit_pg(a[i], b[i]);
    end

    cla_lookahead #(.N(GRP_W)) u_la (
        .pg_in  (bpg),
        .cin    (cin),
        .carry  (c_bit),
        .pg_out (grp)
    );

    assign sum = a ^ b ^ c_bit;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
    parameter int unsigned GRP_W   = cla_pkg::DEF_GRP_W,
    parameter int unsigned NUM_GRP = cla_pkg::DEF_NUM_GRP
) (
    input  logic [GRP_W*NUM_GRP-1:0] a,
    input  logic [GRP_W*NUM_GRP-1:0] b,
    input  logic                     cin,
    output logic [GRP_W*NUM_GRP-1:0] sum,
    output logic                     cout,
    output logic [NUM_GRP-1:0]       grp_p,
    output logic [NUM_GRP-1:0]       grp_g
);
    localparam int unsigned WIDTH = GRP_W * NUM_GRP;

    cla_pkg::pg_t [NUM_GRP-1:0] gpg;
    logic [NUM_GRP-1:0]         c_grp;
    cla_pkg::pg_t               top_pg;

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        cla_group #(.GRP_W(GRP_W)) u_grp (
            .a   (a[k*GRP_W +: GRP_W]),
            .b   (b[k*GRP_W +: GRP_W]),
            .cin (c_grp[k]),
            .sum (sum[k*GRP_W +: GRP_W]),
            .grp (gpg[k])
        );
        assign grp_p[k] = gpg[k].p;
        assign grp_g[k] = gpg[k].g;
    end

    // second level: group carries straight from group P/G and cin
    cla_lookahead #(.N(NUM_GRP)) u_la2 (
        .pg_in  (gpg),
        .cin    (cin),
        .carry  (c_grp),
        .pg_out (top_pg)
    );

    assign cout = top_pg.g | (top_pg.p & cin);
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int unsigned GRP_W   = 4,
    parameter int unsigned NUM_GRP = 4
) (
    input logic [GRP_W*NUM_GRP-1:0] a,
    input logic [GRP_W*NUM_GRP-1:0] b,
    input logic                     cin,
    input logic [GRP_W*NUM_GRP-1:0] sum,
    input logic                     cout,
    input logic [NUM_GRP-1:0]       grp_p,
    input logic [NUM_GRP-1:0]       grp_g
);
    localparam int unsigned WIDTH = GRP_W * NUM_GRP;

    always_comb begin
        logic [WIDTH:0]   full;
        logic [GRP_W:0]   slice;
        logic             c;
        full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        p_sum_r1:  assert (sum == full[WIDTH-1:0]);
        p_cout_r2: assert (cout == full[WIDTH]);
        c = cin;
        for (int k = 0; k < NUM_GRP; k++) begin
            slice = {1'b0, a[k*GRP_W +: GRP_W]} + {1'b0, b[k*GRP_W +: GRP_W]};
            p_grp_p_r3: assert (grp_p[k] == &(a[k*GRP_W +: GRP_W] | b[k*GRP_W +: GRP_W]));
            p_grp_g_r4: assert (grp_g[k] == slice[GRP_W]);
            c = grp_g[k] | (grp_p[k] & c);
        end
        p_cascade_r5: assert (cout == c);
    end
endmodule

bind cla_adder cla_adder_chk #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_chk (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_p(grp_p), .grp_g(grp_g)
);

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int nvec  = 0;
    int nfail = 0;

    logic [15:0] a, b, sum;
    logic        cin, cout;
    logic [3:0]  gp, gg;

    logic [3:0]  sa, sb, ssum;
    logic        scin, scout;
    logic [1:0]  sgp, sgg;

    cla_adder u_dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_p(gp), .grp_g(gg)
    );

    cla_adder #(.GRP_W(2), .NUM_GRP(2)) u_small (
        .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout), .grp_p(sgp), .grp_g(sgg)
    );

    task automatic fail(input string req, input logic [31:0] act, input logic [31:0] exp);
        nfail++;
        $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
    endtask

    task automatic run16(input logic [15:0] va, input logic [15:0] vb, input logic vc);
        logic [16:0] full;
        logic [4:0]  sl;
        logic [3:0]  ep, eg;
        logic        c;
        @(negedge clk);
        a = va; b = vb; cin = vc;
        #1;
        nvec++;
        full = {1'b0, va} + {1'b0, vb} + {16'd0, vc};
        for (int k = 0; k < 4; k++) begin
            sl = {1'b0, va[k*4 +: 4]} + {1'b0, vb[k*4 +: 4]};
            eg[k] = sl[4];
            ep[k] = &(va[k*4 +: 4] | vb[k*4 +: 4]);
        end
        if (sum !== full[15:0]) fail("R1 sum", {16'd0, sum}, {16'd0, full[15:0]});
        if (cout !== full[16])  fail("R2 cout", {31'd0, cout}, {31'd0, full[16]});
        if (gp !== ep)          fail("R3 grp_p", {28'd0, gp}, {28'd0, ep});
        if (gg !== eg)          fail("R4 grp_g", {28'd0, gg}, {28'd0, eg});
        c = vc;
        for (int k = 0; k < 4; k++) c = gg[k] | (gp[k] & c);
        if (cout !== c)         fail("R5 cascade", {31'd0, cout}, {31'd0, c});
    endtask

    task automatic run4(input logic [3:0] va, input logic [3:0] vb, input logic vc);
        logic [4:0] full;
        logic [2:0] sl;
        logic [1:0] ep, eg;
        @(negedge clk);
        sa = va; sb = vb; scin = vc;
        #1;
        nvec++;
        full = {1'b0, va} + {1'b0, vb} + {4'd0, vc};
        for (int k = 0; k < 2; k++) begin
            sl = {1'b0, va[k*2 +: 2]} + {1'b0, vb[k*2 +: 2]};
            eg[k] = sl[2];
            ep[k] = &(va[k*2 +: 2] | vb[k*2 +: 2]);
        end
        if ({scout, ssum} !== full || sgp !== ep || sgg !== eg) begin
            nfail++;
            $display("FAIL R8 a=%h b=%h cin=%0d actual=%b_%h_%b_%b expected=%b_%h_%b_%b",
                     va, vb, vc, scout, ssum, sgp, sgg, full[4], full[3:0], ep, eg);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        sa = '0; sb = '0; scin = 1'b0;

        // R6: worked example, plus explicit group vector checks
        run16(16'h1A33, 16'hE5EB, 1'b0);
        nvec++;
        if (gp !== 4'b1110 || gg !== 4'b0010 || cout !== 1'b1) begin
            nfail++;
            $display("FAIL R6 actual=%b_%b_%b expected=1110_0010_1", gp, gg, cout);
        end

        // R7: all ones with unit carry, carry crosses every group
        run16(16'hFFFF, 16'h0000, 1'b1);
        nvec++;
        if (sum !== 16'h0 || cout !== 1'b1 || gp !== 4'hF || gg !== 4'h0) begin
            nfail++;
            $display("FAIL R7 actual=%h_%b_%b_%b expected=0000_1_1111_0000", sum, cout, gp, gg);
        end
        run16(16'hFFFF, 16'h0001, 1'b0);
        nvec++;
        if (sum !== 16'h0 || cout !== 1'b1 || gp !== 4'hF || gg !== 4'h1) begin
            nfail++;
            $display("FAIL R7 actual=%h_%b_%b_%b expected=0000_1_1111_0001", sum, cout, gp, gg);
        end

        // corner vectors, R1 R2
        run16(16'h0000, 16'h0000, 1'b0);
        run16(16'hFFFF, 16'hFFFF, 1'b1);
        run16(16'h8000, 16'h8000, 1'b0);

        // walking generate point across every group boundary
        for (int i = 0; i < 16; i++) begin
            run16(16'h1 << i, 16'hFFFF ^ (16'h1 << i), 1'b0);
            run16(16'h1 << i, (16'hFFFF << i), 1'b1);
        end

        // random vectors
        for (int i = 0; i < 3000; i++)
            run16(16'($urandom), 16'($urandom), 1'($urandom));

        // R8: exhaustive sweep of the small configuration
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int c = 0; c < 2; c++)
                    run4(4'(x), 4'(y), 1'(c));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule